// File: doc/BRIEF.md
# Processor reset and debug-halt sequencer

This block is a control state machine placed beside a pipelined processor core. It arbitrates between two outside requests: a local reset that restarts only the core, and a debug halt that pauses it. The sequencer does not touch the datapath. Instead it drives a fetch stall, a program-counter redirect with a vector select, a debug acknowledge, a reset-taken pulse and a read strobe aimed at the reset address.

A local reset does not cut the core off mid-flight. Fetch stops first, and the instructions already in the pipeline are allowed to retire. Once the pipeline reports empty, the core enters a hold state. It stays there as long as the request is held, pulsing reset-taken and issuing throwaway reads of the reset vector at a fixed interval. While the debug module owns the core, local reset requests are not acted on. A request still present when control is handed back, whether for one single step or for a full resume, is then carried out. A debug halt behaves like a breakpoint: fetch is redirected to the break vector and the acknowledge rises.

Top module: `core_reset_halt_seq`

## Requirements
- R1: While the global reset `rst_n` is low, the block is in the hold state at once, with `fetch_stall`=1 and `rst_taken`, `rd_req`, `dbg_ack`, `redirect` all 0. If `lrst_req` is low on the first clock after release, the core resumes with a reset-vector redirect in that cycle.
- R2: When `lrst_req` is seen while running, `fetch_stall` rises on the next clock. The hold state is not entered, and no `rst_taken` is given, until a clock edge samples `pipe_empty`=1 with `lrst_req` still high.
- R3: Entry into hold from a drain gives `rst_taken`=1 for exactly one cycle. That cycle is the one after the edge that sampled `pipe_empty`.
- R4: While `lrst_req` stays high in hold, `rst_taken` pulses for one cycle every `PERIOD` cycles (default 16), counted from the entry pulse. After a global reset with `lrst_req` held, the first pulse comes `PERIOD` cycles after release.
- R5: `rd_req` (a one-cycle read of the reset address) is raised only together with a `rst_taken` pulse, and only if no earlier read is outstanding. A read stays outstanding from its `rd_req` cycle until a clock edge that samples `rd_done`=1.
- R6: A clock edge that sees `lrst_req` low in hold moves the core to running. In the following cycle `fetch_stall`=0 and `redirect`=1 with `redirect_sel`=0 (reset vector).
- R7: While paused (`dbg_ack`=1), `lrst_req` has no effect. The pause, the stall and the absence of `rst_taken`/`rd_req` persist until `dbg_resume` or `dbg_step`.
- R8: `dbg_step` while paused releases the core for one cycle (`dbg_ack`=0, `fetch_stall`=0). `dbg_resume` releases it for good. In either case a `lrst_req` that is high at the release is carried out through the drain sequence.
- R9: `halt_req` while running, with no local reset, gives `dbg_ack`=1 with `redirect`=1 and `redirect_sel`=1 (break vector) on the next cycle. A single step that ends without a reset returns to the pause the same way.
- R10: `halt_req` while already paused causes no redirect and no change of `dbg_ack`.
- R11: When `halt_req` and `lrst_req` are both high while running, the reset is taken. `dbg_ack` stays 0 through drain and hold, and the pause follows only after the reset has been released.
- R12: If `lrst_req` falls during the drain, the core returns to running on the next cycle with no `rst_taken` and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global asynchronous reset, active low |
| lrst_req | input | 1 | Local core reset request, level |
| halt_req | input | 1 | Debug halt request, level |
| pipe_empty | input | 1 | Pipeline holds no instruction in flight |
| dbg_resume | input | 1 | Debug module resume strobe |
| dbg_step | input | 1 | Debug module single-step strobe |
| rd_done | input | 1 | Completion of the outstanding reset-vector read |
| rst_taken | output | 1 | One-cycle reset-taken pulse |
| dbg_ack | output | 1 | Core is paused under debug control |
| fetch_stall | output | 1 | Stop issuing new instructions |
| redirect | output | 1 | One-cycle program-counter redirect |
| redirect_sel | output | 1 | Vector for redirect: 0 reset, 1 break |
| rd_req | output | 1 | One-cycle read strobe to the reset address |

## Verification
Two pairs of functions can land on the same clock edge. The first is a debug halt and a local reset that become eligible together while the core runs. The bench raises both in one cycle and then checks that the acknowledge stays low through drain and hold, and that it rises with a break redirect only one cycle after the reset-vector redirect. The second is a single-step release that meets a pending local reset. Here the one-cycle release is followed directly by a drain and a reset-taken pulse, rather than a return to the pause. The periodic pulses and dummy reads are swept cycle by cycle against an arithmetic schedule, with the bus completion placed between ticks.

// File: rtl/core_reset_halt_seq.sv
module core_reset_halt_seq #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lrst_req,
  input  logic halt_req,
  input  logic pipe_empty,
  input  logic dbg_resume,
  input  logic dbg_step,
  input  logic rd_done,
  output logic rst_taken,
  output logic dbg_ack,
  output logic fetch_stall,
  output logic redirect,
  output logic redirect_sel,
  output logic rd_req
);

  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  typedef enum logic [2:0] {S_RUN, S_DRAIN, S_HOLD, S_PAUSE, S_STEP} state_t;

  state_t        st, nxt;
  logic [CW-1:0] cnt;
  logic          rd_busy;
  logic          tick;
  logic          redir_n;

  assign tick = lrst_req && ((st == S_DRAIN && pipe_empty) || (st == S_HOLD && cnt == LAST));

  assign redir_n = !lrst_req && ((st == S_HOLD) || (st == S_STEP) || (st == S_RUN && halt_req));

  assign dbg_ack     = (st == S_PAUSE);
  assign fetch_stall = (st != S_RUN) && (st != S_STEP);

  always_comb begin
    nxt = st;
    unique case (st)
      S_RUN:   if (lrst_req) nxt = S_DRAIN;
               else if (halt_req) nxt = S_PAUSE;
      S_DRAIN: if (!lrst_req) nxt = S_RUN;
               else if (pipe_empty) nxt = S_HOLD;
      S_HOLD:  if (!lrst_req) nxt = S_RUN;
      S_PAUSE: if (dbg_resume) nxt = S_RUN;
               else if (dbg_step) nxt = S_STEP;
      S_STEP:  nxt = lrst_req ? S_DRAIN : S_PAUSE;
      default: nxt = S_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_HOLD;
      cnt          <= '0;
      rst_taken    <= 1'b0;
      rd_req       <= 1'b0;
      rd_busy      <= 1'b0;
      redirect     <= 1'b0;
      redirect_sel <= 1'b0;
    end else begin
      st           <= nxt;
      rst_taken    <= tick;
      rd_req       <= tick && !rd_busy;
      rd_busy      <= rd_req || (rd_busy && !rd_done);
      redirect     <= redir_n;
      redirect_sel <= (st != S_HOLD);
      if (st == S_HOLD && lrst_req)
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      else
        cnt <= '0;
    end
  end

  assert_taken_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_taken |=> !rst_taken);

  assert_taken_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_taken |-> (fetch_stall && !dbg_ack));

  assert_drain_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && !pipe_empty) |=> !rst_taken);

  assert_read_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rst_taken);

  assert_pause_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_ack && !dbg_resume && !dbg_step) |=> dbg_ack);

  assert_break_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && redirect_sel) |-> dbg_ack);

  assert_reset_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !redirect_sel) |-> !fetch_stall);

endmodule

// File: tb/core_reset_halt_seq_test.sv
module core_reset_halt_seq_test;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n, lrst_req, halt_req, pipe_empty, dbg_resume, dbg_step, rd_done;
  logic rst_taken, dbg_ack, fetch_stall, redirect, redirect_sel, rd_req;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  core_reset_halt_seq #(.PERIOD(P)) uut (
    .clk(clk), .rst_n(rst_n), .lrst_req(lrst_req), .halt_req(halt_req),
    .pipe_empty(pipe_empty), .dbg_resume(dbg_resume), .dbg_step(dbg_step),
    .rd_done(rd_done), .rst_taken(rst_taken), .dbg_ack(dbg_ack),
    .fetch_stall(fetch_stall), .redirect(redirect), .redirect_sel(redirect_sel),
    .rd_req(rd_req)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic t, input logic a,
                            input logic s, input logic r, input logic sl, input logic rd);
    checks++;
    if (rst_taken !== t || dbg_ack !== a || fetch_stall !== s || redirect !== r ||
        (r && redirect_sel !== sl) || rd_req !== rd) begin
      errors++;
      $display("FAIL %s: taken/ack/stall/redir/sel/rd got %b%b%b%b%b%b expected %b%b%b%b%b%b",
               tag, rst_taken, dbg_ack, fetch_stall, redirect, redirect_sel, rd_req,
               t, a, s, r, sl, rd);
    end
  endtask

  task automatic pulse_done();
    rd_done = 1'b1;
    step();
    rd_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: run did not finish, got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lrst_req = 0; halt_req = 0; pipe_empty = 1;
    dbg_resume = 0; dbg_step = 0; rd_done = 0;
    step(); step();
    expect_out("R1 reset state", 0, 0, 1, 0, 0, 0);
    rst_n = 1'b1;
    step();
    expect_out("R1 leave to run", 0, 0, 0, 1, 0, 0);
    step();
    expect_out("R1 running", 0, 0, 0, 0, 0, 0);

    pipe_empty = 0; lrst_req = 1;
    step();
    expect_out("R2 drain stall", 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step();
      expect_out("R2 drain wait", 0, 0, 1, 0, 0, 0);
    end
    pipe_empty = 1;
    step();
    expect_out("R3 entry pulse", 1, 0, 1, 0, 0, 1);
    for (int k = 1; k <= 20; k++) begin
      if (k == 13) rd_done = 1;
      step();
      rd_done = 0;
      expect_out("R4 R5 periodic", (k % P) == 0, 0, 1, 0, 0, k == 16);
    end

    lrst_req = 0;
    step();
    expect_out("R6 release", 0, 0, 0, 1, 0, 0);
    pulse_done();

    halt_req = 1;
    step();
    expect_out("R9 halt", 0, 1, 1, 1, 1, 0);
    step();
    expect_out("R10 held halt", 0, 1, 1, 0, 0, 0);
    halt_req = 0;
    step();
    halt_req = 1;
    step();
    expect_out("R10 halt again", 0, 1, 1, 0, 0, 0);
    halt_req = 0;

    lrst_req = 1;
    for (int i = 0; i < 5; i++) begin
      step();
      expect_out("R7 reset ignored", 0, 1, 1, 0, 0, 0);
    end

    dbg_step = 1;
    step();
    dbg_step = 0;
    expect_out("R8 step release", 0, 0, 0, 0, 0, 0);
    step();
    expect_out("R8 step drains", 0, 0, 1, 0, 0, 0);
    step();
    expect_out("R8 step reset", 1, 0, 1, 0, 0, 1);
    lrst_req = 0;
    step();
    expect_out("R6 release2", 0, 0, 0, 1, 0, 0);
    pulse_done();

    halt_req = 1;
    step();
    halt_req = 0;
    expect_out("R9 halt2", 0, 1, 1, 1, 1, 0);
    dbg_step = 1;
    step();
    dbg_step = 0;
    expect_out("R8 plain step", 0, 0, 0, 0, 0, 0);
    step();
    expect_out("R9 step returns", 0, 1, 1, 1, 1, 0);
    lrst_req = 1;
    step(); step();
    expect_out("R7 paused", 0, 1, 1, 0, 0, 0);
    dbg_resume = 1;
    step();
    dbg_resume = 0;
    expect_out("R8 resume", 0, 0, 0, 0, 0, 0);
    step();
    expect_out("R8 resume drain", 0, 0, 1, 0, 0, 0);
    step();
    expect_out("R8 resume reset", 1, 0, 1, 0, 0, 1);
    lrst_req = 0;
    step();
    expect_out("R6 release3", 0, 0, 0, 1, 0, 0);
    pulse_done();

    halt_req = 1; lrst_req = 1; pipe_empty = 0;
    step();
    expect_out("R11 reset wins", 0, 0, 1, 0, 0, 0);
    step(); step();
    expect_out("R11 ack low drain", 0, 0, 1, 0, 0, 0);
    pipe_empty = 1;
    step();
    expect_out("R11 reset taken", 1, 0, 1, 0, 0, 1);
    step();
    expect_out("R11 ack low hold", 0, 0, 1, 0, 0, 0);
    lrst_req = 0;
    step();
    expect_out("R11 released", 0, 0, 0, 1, 0, 0);
    step();
    expect_out("R11 pause after", 0, 1, 1, 1, 1, 0);
    halt_req = 0; dbg_resume = 1;
    step();
    dbg_resume = 0;
    expect_out("R8 resume clean", 0, 0, 0, 0, 0, 0);
    pulse_done();

    pipe_empty = 0; lrst_req = 1;
    step();
    expect_out("R12 drain", 0, 0, 1, 0, 0, 0);
    lrst_req = 0;
    step();
    expect_out("R12 abort", 0, 0, 0, 0, 0, 0);
    step();
    expect_out("R12 no pulse", 0, 0, 0, 0, 0, 0);

    pipe_empty = 1; lrst_req = 1;
    step(); step();
    expect_out("R3 pre global", 1, 0, 1, 0, 0, 1);
    step();
    #0.5 rst_n = 1'b0;
    #0.5;
    expect_out("R1 async reset", 0, 0, 1, 0, 0, 0);
    rst_n = 1'b1;
    for (int k = 1; k <= 2 * P; k++) begin
      step();
      expect_out("R4 after global", (k % P) == 0, 0, 1, 0, 0, k == P);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule